// File: doc/BRIEF.md
# Programmable Self-Synchronizing Bit Scrambler

This block whitens or restores a serial bit stream, one bit per enabled clock. A seven-stage history register holds the most recent bits of the scrambled line stream. A runtime-programmable tap mask picks which stages feed a modulo-2 sum. Each accepted input bit is XORed with that sum to form the output bit.

In scramble mode, the output bit enters the history register. In descramble mode, the received line bit enters the register instead. The receiver's history therefore matches the transmitter's after seven bits, whatever state it started in, so no seed exchange is needed. The same logic serves preamble, header and payload alike.

A controller pulses the seed load at packet start to preset the history to 0x6C. A mask of zero turns the block into a registered pass-through.

Top module: `sync_scrambler`

## Requirements
- R1: After reset, dout and dout_vld are 0, the tap mask is 0x48 and the history register holds 0x6C.
- R2: dout and dout_vld are registered. dout_vld is 1 in the cycle after a cycle with bit_en=1 and seed_load=0, and 0 otherwise.
- R3: With mode_rx=0 (scramble), an accepted bit gives dout = din XOR parity(history AND mask). This dout value is shifted into history bit 0 while bits 0..5 move up to bits 1..6.
- R4: With mode_rx=1 (descramble), the same XOR forms dout, but din itself is shifted into history bit 0.
- R5: Mask bit i selects history bit i, which holds the line bit accepted i+1 bits earlier. Single-bit masks on each stage produce the matching delayed feedback.
- R6: A cycle with tap_wr_en=1 loads tap_wr_data into the mask. A bit accepted in that same cycle still uses the old mask, and later bits use the new one.
- R7: With the mask at 0, every accepted bit appears unchanged on dout one cycle later.
- R8: seed_load=1 sets the history to 0x6C on the next edge and takes priority over bit_en: a bit offered in that cycle is dropped and gives no dout_vld.
- R9: While bit_en=0 and seed_load=0, the history and dout hold, so idle gaps do not change the output sequence.
- R10: In descramble mode, dout equals the original data from the eighth bit onward, whatever the starting history, once the line stream was scrambled with the same mask.
- R11: A stream scrambled from the seed and then descrambled from the seed with the same mask returns the original data bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_wr_en | input | 1 | Load tap mask from tap_wr_data |
| tap_wr_data | input | 7 | New tap mask, bit i selects delay stage i+1 |
| seed_load | input | 1 | Preset history to 0x6C |
| mode_rx | input | 1 | 0 = scramble, 1 = descramble |
| bit_en | input | 1 | Input bit valid this cycle |
| din | input | 1 | Serial input bit |
| dout | output | 1 | Serial output bit |
| dout_vld | output | 1 | dout carries a new bit |

## Verification
The assertions assume every input is at a known level from the first clock edge after reset. They also assume mode_rx does not change between a bit's acceptance and the check of the history shift that follows it.

The stimulus drives all inputs on the falling edge and keeps them steady across each rising edge. It changes mode only between packets, each started with a seed load. Mask writes that coincide with a data bit are made on purpose, to check the old-mask rule.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned SCR_W = 7;
  localparam logic [SCR_W-1:0] SCR_SEED = 7'h6C;
  localparam logic [SCR_W-1:0] SCR_TAPS_RST = 7'h48;

  typedef enum logic {
    SCR_MODE_TX = 1'b0,
    SCR_MODE_RX = 1'b1
  } scr_mode_e;
endpackage

// File: rtl/scr_tap_reg.sv
module scr_tap_reg #(
  parameter int unsigned W = 7,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] taps_q
);
  logic [W-1:0] taps_d;

  always_comb begin
    taps_d = taps_q;
    if (wr_en) taps_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps_q <= RST_VAL;
    else        taps_q <= taps_d;
  end

  // R6: a write lands on the next edge
  p_tap_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> taps_q == $past(wr_data));
  p_tap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(taps_q));
endmodule

// File: rtl/scr_parity.sv
module scr_parity #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] vec,
  output logic         par
);
  logic [W:0] chain;

  assign chain[0] = 1'b0;
  for (genvar gi = 0; gi < W; gi++) begin : g_xor
    assign chain[gi+1] = chain[gi] ^ vec[gi];
  end
  assign par = chain[W];
endmodule

// File: rtl/scr_hist_reg.sv
module scr_hist_reg #(
  parameter int unsigned W = 7,
  parameter logic [W-1:0] SEED = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  input  logic         shift_bit,
  output logic [W-1:0] hist_q
);
  logic [W-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (load)     hist_d = SEED;
    else if (adv) hist_d = {hist_q[W-2:0], shift_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= SEED;
    else        hist_q <= hist_d;
  end

  // R3: older stages move up one place per accepted bit
  p_shift_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> hist_q[W-1:1] == $past(hist_q[W-2:0]));
  // R8: seed preset
  p_seed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> hist_q == SEED);
  // R9: idle holds
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(hist_q));
endmodule

// File: rtl/sync_scrambler.sv
module sync_scrambler
  import scr_pkg::*;
#(
  parameter int unsigned W = SCR_W,
  parameter logic [W-1:0] SEED = SCR_SEED,
  parameter logic [W-1:0] TAPS_RST = SCR_TAPS_RST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tap_wr_en,
  input  logic [W-1:0] tap_wr_data,
  input  logic         seed_load,
  input  logic         mode_rx,
  input  logic         bit_en,
  input  logic         din,
  output logic         dout,
  output logic         dout_vld
);
  logic [W-1:0] taps_q;
  logic [W-1:0] hist_q;
  logic [W-1:0] tapped;
  logic         fb_par;
  logic         line_bit;
  logic         shift_bit;
  logic         accept;
  logic         dout_d;
  logic         vld_d;
  scr_mode_e    mode;

  assign mode   = scr_mode_e'(mode_rx);
  assign accept = bit_en & ~seed_load;
  assign tapped = hist_q & taps_q;

  scr_tap_reg #(.W(W), .RST_VAL(TAPS_RST)) u_taps (
    .clk(clk), .rst_n(rst_n), .wr_en(tap_wr_en),
    .wr_data(tap_wr_data), .taps_q(taps_q)
  );

  scr_parity #(.W(W)) u_par (.vec(tapped), .par(fb_par));

  assign line_bit  = din ^ fb_par;
  assign shift_bit = (mode == SCR_MODE_RX) ? din : line_bit;

  scr_hist_reg #(.W(W), .SEED(SEED)) u_hist (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .adv(accept),
    .shift_bit(shift_bit), .hist_q(hist_q)
  );

  always_comb begin
    dout_d = dout;
    vld_d  = accept;
    if (accept) dout_d = line_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= 1'b0;
      dout_vld <= 1'b0;
    end else begin
      dout     <= dout_d;
      dout_vld <= vld_d;
    end
  end

  // R2: valid follows an accepted bit by one cycle
  p_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld == $past(bit_en && !seed_load));
  // R3: scramble mode feeds back the emitted bit
  p_tx_feed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mode_rx) |=> hist_q[0] == dout);
  // R4: descramble mode feeds back the received bit
  p_rx_feed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_rx) |=> hist_q[0] == $past(din));
  // R7: zero mask passes data through
  p_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && taps_q == '0) |=> dout == $past(din));
  // R9: output holds while idle
  p_dout_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(dout));
endmodule

// File: tb/sync_scrambler_tb_top.sv
module sync_scrambler_tb_top;
  logic       clk;
  logic       rst_n;
  logic       tap_wr_en;
  logic [6:0] tap_wr_data;
  logic       seed_load;
  logic       mode_rx;
  logic       bit_en;
  logic       din;
  logic       dout;
  logic       dout_vld;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  logic [6:0] m_hist;
  logic [6:0] m_taps;
  logic       m_out;
  logic [15:0] cap;

  // table: [23] mode_rx, [22:16] mask, [15:0] data (bit 0 sent first)
  localparam int NV = 10;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 7'h48, 16'h0000}, {1'b0, 7'h48, 16'hFFFF},
    {1'b0, 7'h48, 16'hA5C3}, {1'b1, 7'h48, 16'h1E2D},
    {1'b0, 7'h01, 16'h00F0}, {1'b0, 7'h08, 16'h8001},
    {1'b0, 7'h40, 16'h3C3C}, {1'b1, 7'h7F, 16'h5AA5},
    {1'b0, 7'h00, 16'hC0DE}, {1'b1, 7'h22, 16'h0F0F}
  };

  sync_scrambler dut_i (
    .clk(clk), .rst_n(rst_n), .tap_wr_en(tap_wr_en), .tap_wr_data(tap_wr_data),
    .seed_load(seed_load), .mode_rx(mode_rx), .bit_en(bit_en), .din(din),
    .dout(dout), .dout_vld(dout_vld)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic model_step(input logic b, input logic rx);
    m_out  = b ^ (^(m_hist & m_taps));
    m_hist = {m_hist[5:0], rx ? b : m_out};
  endtask

  task automatic write_taps(input logic [6:0] t);
    @(negedge clk);
    tap_wr_en = 1; tap_wr_data = t;
    @(negedge clk);
    tap_wr_en = 0;
    m_taps = t;
  endtask

  task automatic load_seed;
    @(negedge clk);
    seed_load = 1;
    @(negedge clk);
    seed_load = 0;
    m_hist = 7'h6C;
  endtask

  // drive one bit; dout sampled at the following falling edge
  task automatic send(input logic b, output logic o, output logic v);
    @(negedge clk);
    bit_en = 1; din = b;
    @(negedge clk);
    bit_en = 0;
    o = dout; v = dout_vld;
  endtask

  initial begin
    logic o, v;
    rst_n = 0; tap_wr_en = 0; tap_wr_data = 0; seed_load = 0;
    mode_rx = 0; bit_en = 0; din = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 dout", dout, 0);
    chk("R1 dout_vld", dout_vld, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: default taps 0x48 and seed 0x6C, observed via scrambled zeros
    m_hist = 7'h6C; m_taps = 7'h48;
    for (int i = 0; i < 8; i++) begin
      send(1'b0, o, v);
      model_step(1'b0, 1'b0);
      chk("R1 default seed/taps", o, m_out);
    end

    // table walk: R3, R4, R5, R7, R2
    for (int k = 0; k < NV; k++) begin
      mode_rx = VEC[k][23];
      write_taps(VEC[k][22:16]);
      load_seed();
      for (int i = 0; i < 16; i++) begin
        send(VEC[k][i], o, v);
        model_step(VEC[k][i], VEC[k][23]);
        chk(VEC[k][23] ? "R4 descramble" : (VEC[k][22:16] == 0 ? "R7 passthru" : "R3/R5 scramble"), o, m_out);
        chk("R2 vld", v, 1);
      end
    end

    // R2: valid drops when idle
    @(negedge clk);
    chk("R2 vld idle", dout_vld, 0);

    // R9: idle gaps do not alter the sequence
    mode_rx = 0; write_taps(7'h48); load_seed();
    for (int i = 0; i < 6; i++) begin
      send(i[0], o, v);
      model_step(i[0], 1'b0);
      repeat (i) @(negedge clk);
      chk("R9 hold dout", dout, m_out);
      chk("R9 seq", o, m_out);
    end

    // R6: mask write in same cycle as a bit uses the old mask
    load_seed();
    @(negedge clk);
    tap_wr_en = 1; tap_wr_data = 7'h00; bit_en = 1; din = 1;
    @(negedge clk);
    tap_wr_en = 0; bit_en = 0;
    model_step(1'b1, 1'b0);
    chk("R6 old mask", dout, m_out);
    m_taps = 7'h00;
    send(1'b1, o, v);
    model_step(1'b1, 1'b0);
    chk("R6 new mask", o, 1);

    // R8: seed load wins over bit_en
    write_taps(7'h48);
    @(negedge clk);
    seed_load = 1; bit_en = 1; din = 1;
    @(negedge clk);
    seed_load = 0; bit_en = 0;
    chk("R8 dropped bit vld", dout_vld, 0);
    m_hist = 7'h6C;
    for (int i = 0; i < 8; i++) begin
      send(1'b1, o, v);
      model_step(1'b1, 1'b0);
      chk("R8 seed seq", o, m_out);
    end

    // R10: self-synchronization from an unknown history
    mode_rx = 1;
    for (int i = 0; i < 5; i++) send(1'b1, o, v);  // scramble the history
    m_hist = 7'h6C; m_taps = 7'h48;
    for (int i = 0; i < 20; i++) begin
      logic db;
      db = ((i * 7 + 3) % 5) < 2;
      model_step(db, 1'b0);     // transmitter model gives the line bit
      send(m_out, o, v);
      if (i >= 7) chk("R10 sync", o, db);
    end

    // R11: loopback through the DUT
    mode_rx = 0; load_seed();
    for (int i = 0; i < 16; i++) begin
      send(VEC[2][i], o, v);
      cap[i] = o;
    end
    mode_rx = 1; load_seed();
    for (int i = 0; i < 16; i++) begin
      send(cap[i], o, v);
      chk("R11 loopback", o, VEC[2][i]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule